// File: doc/BRIEF.md
# Per-Line Register Protection Filter

This block guards a small per-line configuration register file against accesses that lack the right attributes. Every line owns a secure bit and a privileged bit. Each bus access arrives with a secure flag and a privileged flag. The filter works out which lines the current access may touch. It then masks writes and read data bit by bit, or by whole byte fields, so that one access can reach some lines of a register and not others.

The register file holds four things. The first is a per-line control word, one bit per line. The second is a set of port-select words: each line has one 8-bit field, and four fields are packed into each 32-bit word. The third is the pair of protection registers, which guard each other. The fourth is a lock bit that can be set once. After the lock is set, the protection registers cannot change until reset. Two kinds of access are refused and raise a one-cycle illegal-access pulse. The first is a nonsecure write to the secure-configuration register. The second is any nonsecure access to the lock register.

The word map is as follows:
- 0x00: control
- 0x04: secure configuration
- 0x08: privileged configuration
- 0x0C: lock (bit 0)
- 0x20 upward: port-select words

Address bits [1:0] are ignored. Read data is combinational for the access on the bus in the same cycle. Writes take effect at the clock edge that samples the access.

Top module: `line_prot_filter`

## Requirements
- R1: After reset, these all read zero:
  - every control bit, port-select field, secure bit and privileged bit;
  - the lock bit;
  - the illegal-access pulse.
- R2: A write to the control word at 0x00 updates bit i only when the byte lane i/8 is enabled and line i permits the access. All other bits keep their value.
- R3: For a line whose secure bit is 1, a nonsecure access reads 0 in that line's control bit, and a nonsecure write leaves that bit unchanged.
- R4: For a line whose privileged bit is 1, an unprivileged access reads 0 in that line's control bit, and an unprivileged write leaves that bit unchanged.
- R5: The 8-bit port-select field of line k sits in byte k%4 of the word at 0x20+4*(k/4). The secure and privileged bits of line k protect this field as a unit, for both read and write, combined with that byte's lane enable.
- R6: A nonsecure write to the secure-configuration register (0x04) changes nothing and raises the illegal pulse. A nonsecure read of that register returns its true contents.
- R7: The two protection registers guard each other:
  - A secure write to the secure-configuration register sets the secure bit of a privileged line only if the access is privileged.
  - A privileged write to the privileged-configuration register (0x08) sets the privileged bit of a secure line only if the access is secure.
  - An unprivileged write to 0x08 changes nothing and raises no pulse.
  - Either protection register reads back its true contents to any access.
- R8: A nonsecure read of the lock register (0x0C) returns 0 and raises the illegal pulse. A nonsecure write to it changes nothing and raises the illegal pulse.
- R9: A secure write with data bit 0 equal to 1 and byte lane 0 enabled sets the lock. After that:
  - writing 0 does not clear the lock;
  - both protection registers keep their values until reset;
  - a secure read of 0x0C returns 1.
- R10: The illegal pulse is high for exactly the one cycle after an offending access. It is never raised by an allowed access or by a refused line-level access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Access carries the secure attribute |
| req_priv | input | 1 | Access carries the privileged attribute |
| req_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane enables for writes |
| rsp_rdata | output | 32 | Filtered read data for the current access |
| illegal_pulse | output | 1 | One-cycle pulse after a refused protected access |
| line_ctrl | output | NUM_LINES | Per-line control bits |
| port_sel | output | NUM_SEL*8 | Per-line port-select fields, line k at bits [8k+7:8k] |
| line_secure | output | NUM_LINES | Per-line secure bits |
| line_priv | output | NUM_LINES | Per-line privileged bits |
| prot_locked | output | 1 | Protection configuration is locked |

## Verification
A wrong per-line permission shows up in the same cycle as a read value that is too open or too closed. It shows one edge later as a control bit or a select field that changed when it should have held, or held when it should have changed. A fault in the cross-guard between the two protection registers appears in the secure or privileged output one edge after the write. A lost lock appears on the next protection write that goes through. A misrouted illegal-access decision shows up on the pulse output one cycle after the access. That cycle is sampled first to see the pulse, and the next cycle is sampled to confirm it has fallen.

// File: rtl/line_prot_pkg.sv
// Shared constants, register selector type and permission helper for the
// per-line protection filter. Assumes a 32-bit data path with 8-bit lanes.
package line_prot_pkg;

    localparam int DATA_W          = 32;
    localparam int BE_W            = DATA_W / 8;
    localparam int FIELD_W         = 8;
    localparam int FIELDS_PER_WORD = DATA_W / FIELD_W;

    // Word indices (byte address / 4) of the register map
    localparam int WORD_CTRL     = 0;
    localparam int WORD_SEC      = 1;
    localparam int WORD_PRIV     = 2;
    localparam int WORD_LOCK     = 3;
    localparam int WORD_SEL_BASE = 8;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTRL,
        RG_SEC,
        RG_PRIV,
        RG_LOCK,
        RG_SEL
    } reg_kind_e;

    // A line admits an access when each protection it carries is matched
    function automatic logic line_admits(input logic sec_bit, input logic priv_bit,
                                         input logic acc_sec, input logic acc_priv);
        return (!sec_bit || acc_sec) && (!priv_bit || acc_priv);
    endfunction

endpackage

// File: rtl/line_access_mask.sv
// Computes, for every line, whether the current access attributes satisfy
// that line's secure and privileged settings. Purely combinational.
module line_access_mask
    import line_prot_pkg::*;
#(
    parameter int NUM_LINES = 24
) (
    input  logic [NUM_LINES-1:0] sec_cfg,
    input  logic [NUM_LINES-1:0] priv_cfg,
    input  logic                 acc_secure,
    input  logic                 acc_priv,
    output logic [NUM_LINES-1:0] allow
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        // Per-line permission decision
        assign allow[i] = line_admits(sec_cfg[i], priv_cfg[i], acc_secure, acc_priv);
    end

endmodule

// File: rtl/prot_cfg_regs.sv
// Holds the per-line secure and privileged configuration plus the one-shot
// lock. Each protection register is write-guarded by the other one's bits.
// Assumes the write strobes are already decoded and qualified by req_valid.
module prot_cfg_regs #(
    parameter int NUM_LINES = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_sec,
    input  logic                 wr_priv,
    input  logic                 wr_lock,
    input  logic                 acc_secure,
    input  logic                 acc_priv,
    input  logic [NUM_LINES-1:0] wbits,
    input  logic [NUM_LINES-1:0] lane_en,
    input  logic                 lock_bit,
    output logic [NUM_LINES-1:0] sec_q,
    output logic [NUM_LINES-1:0] priv_q,
    output logic                 lock_q
);

    logic [NUM_LINES-1:0] sec_wmask;
    logic [NUM_LINES-1:0] priv_wmask;

    // Which secure bits a write may change: secure access, unlocked, and
    // privileged lines only when the access is privileged
    always_comb begin
        sec_wmask = '0;
        if (wr_sec && acc_secure && !lock_q)
            sec_wmask = lane_en & (acc_priv ? {NUM_LINES{1'b1}} : ~priv_q);
    end

    // Which privileged bits a write may change: privileged access, unlocked,
    // and secure lines only when the access is secure
    always_comb begin
        priv_wmask = '0;
        if (wr_priv && acc_priv && !lock_q)
            priv_wmask = lane_en & (acc_secure ? {NUM_LINES{1'b1}} : ~sec_q);
    end

    // Secure configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) sec_q <= '0;
        else        sec_q <= (sec_q & ~sec_wmask) | (wbits & sec_wmask);
    end

    // Privileged configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) priv_q <= '0;
        else        priv_q <= (priv_q & ~priv_wmask) | (wbits & priv_wmask);
    end

    // Sticky lock: set by a secure write of 1, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)                                  lock_q <= 1'b0;
        else if (wr_lock && acc_secure && lock_bit)  lock_q <= 1'b1;
    end

endmodule

// File: rtl/line_cfg_regs.sv
// Per-line control bits and 8-bit port-select fields. A bit or field updates
// only when its lane is enabled and its line admits the access.
// Assumes allow[] comes from line_access_mask for the same access.
module line_cfg_regs
    import line_prot_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int NUM_SEL   = 16,
    parameter int SW_IDX_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_ctrl,
    input  logic                      wr_sel,
    input  logic [SW_IDX_W-1:0]       sel_idx,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [BE_W-1:0]           be,
    input  logic [NUM_LINES-1:0]      allow,
    output logic [NUM_LINES-1:0]      ctrl_q,
    output logic [NUM_SEL*FIELD_W-1:0] sel_q
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ctrl
        // Control bit of line i with lane and permission gating
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[i] <= 1'b0;
            else if (wr_ctrl && allow[i] && be[i / 8])
                ctrl_q[i] <= wdata[i];
        end
    end

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
        localparam int LANE = k % FIELDS_PER_WORD;
        localparam int WIDX = k / FIELDS_PER_WORD;
        logic hit;
        assign hit = wr_sel && (sel_idx == SW_IDX_W'(WIDX)) && allow[k] && be[LANE];
        // Port-select field of line k, written as a whole byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[k*FIELD_W +: FIELD_W] <= '0;
            else if (hit)
                sel_q[k*FIELD_W +: FIELD_W] <= wdata[LANE*FIELD_W +: FIELD_W];
        end
    end

endmodule

// File: rtl/line_prot_filter.sv
// Top of the per-line protection filter: decodes the word address, gates
// writes into the protection and per-line register groups, filters read
// data per line and produces the illegal-access pulse. Assumes one access
// per cycle with read data taken combinationally in the access cycle.
module line_prot_filter
    import line_prot_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int NUM_SEL   = 16,
    parameter int ADDR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic                       req_secure,
    input  logic                       req_priv,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [31:0]                req_wdata,
    input  logic [3:0]                 req_be,
    output logic [31:0]                rsp_rdata,
    output logic                       illegal_pulse,
    output logic [NUM_LINES-1:0]       line_ctrl,
    output logic [NUM_SEL*8-1:0]       port_sel,
    output logic [NUM_LINES-1:0]       line_secure,
    output logic [NUM_LINES-1:0]       line_priv,
    output logic                       prot_locked
);

    localparam int WA_W      = ADDR_W - 2;
    localparam int SEL_WORDS = (NUM_SEL + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
    localparam int SW_IDX_W  = (SEL_WORDS > 1) ? $clog2(SEL_WORDS) : 1;

    logic [WA_W-1:0]      word;
    reg_kind_e            kind;
    logic [SW_IDX_W-1:0]  sel_idx;
    logic [NUM_LINES-1:0] allow;
    logic [NUM_LINES-1:0] lane_en;
    logic                 do_wr;
    logic                 bad_access;

    assign word  = req_addr[ADDR_W-1:2];
    assign do_wr = req_valid && req_write;

    // Address decode into a register kind and a port-select word index
    always_comb begin
        kind    = RG_NONE;
        sel_idx = '0;
        if (word == WA_W'(WORD_CTRL))       kind = RG_CTRL;
        else if (word == WA_W'(WORD_SEC))   kind = RG_SEC;
        else if (word == WA_W'(WORD_PRIV))  kind = RG_PRIV;
        else if (word == WA_W'(WORD_LOCK))  kind = RG_LOCK;
        else if (word >= WA_W'(WORD_SEL_BASE) &&
                 word <  WA_W'(WORD_SEL_BASE + SEL_WORDS)) begin
            kind    = RG_SEL;
            sel_idx = SW_IDX_W'(word - WA_W'(WORD_SEL_BASE));
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
        // Byte-lane enable expanded to the bit of line i
        assign lane_en[i] = req_be[i / 8];
    end

    line_access_mask #(.NUM_LINES(NUM_LINES)) u_mask (
        .sec_cfg    (line_secure),
        .priv_cfg   (line_priv),
        .acc_secure (req_secure),
        .acc_priv   (req_priv),
        .allow      (allow)
    );

    prot_cfg_regs #(.NUM_LINES(NUM_LINES)) u_prot (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sec     (do_wr && kind == RG_SEC),
        .wr_priv    (do_wr && kind == RG_PRIV),
        .wr_lock    (do_wr && kind == RG_LOCK && req_be[0]),
        .acc_secure (req_secure),
        .acc_priv   (req_priv),
        .wbits      (req_wdata[NUM_LINES-1:0]),
        .lane_en    (lane_en),
        .lock_bit   (req_wdata[0]),
        .sec_q      (line_secure),
        .priv_q     (line_priv),
        .lock_q     (prot_locked)
    );

    line_cfg_regs #(
        .NUM_LINES (NUM_LINES),
        .NUM_SEL   (NUM_SEL),
        .SW_IDX_W  (SW_IDX_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (do_wr && kind == RG_CTRL),
        .wr_sel  (do_wr && kind == RG_SEL),
        .sel_idx (sel_idx),
        .wdata   (req_wdata),
        .be      (req_be),
        .allow   (allow),
        .ctrl_q  (line_ctrl),
        .sel_q   (port_sel)
    );

    // Filtered read data for the addressed register
    always_comb begin
        rsp_rdata = '0;
        unique case (kind)
            RG_CTRL: rsp_rdata[NUM_LINES-1:0] = line_ctrl & allow;
            RG_SEC:  rsp_rdata[NUM_LINES-1:0] = line_secure;
            RG_PRIV: rsp_rdata[NUM_LINES-1:0] = line_priv;
            RG_LOCK: rsp_rdata[0]             = req_secure & prot_locked;
            RG_SEL: begin
                for (int k = 0; k < NUM_SEL; k++) begin
                    if (sel_idx == SW_IDX_W'(k / FIELDS_PER_WORD) && allow[k])
                        rsp_rdata[(k % FIELDS_PER_WORD)*FIELD_W +: FIELD_W] =
                            port_sel[k*FIELD_W +: FIELD_W];
                end
            end
            default: rsp_rdata = '0;
        endcase
    end

    // Refused accesses that are reported: nonsecure write to the secure
    // configuration, any nonsecure access to the lock register
    assign bad_access = req_valid && !req_secure &&
                        ((kind == RG_SEC && req_write) || kind == RG_LOCK);

    // Registered one-cycle illegal-access pulse
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_pulse <= 1'b0;
        else        illegal_pulse <= bad_access;
    end

endmodule

// File: rtl/line_prot_checker.sv
// Temporal checks on the protection filter's ports, attached by bind.
module line_prot_checker #(
    parameter int NUM_LINES = 24,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 req_secure,
    input logic                 req_priv,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [31:0]          rsp_rdata,
    input logic                 illegal_pulse,
    input logic [NUM_LINES-1:0] line_ctrl,
    input logic [NUM_LINES-1:0] line_secure,
    input logic [NUM_LINES-1:0] line_priv,
    input logic                 prot_locked
);

    logic [ADDR_W-3:0] wa;
    assign wa = req_addr[ADDR_W-1:2];

    // R3: nonsecure write never changes control bits of secure lines
    p_ctrl_secure_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure && wa == 0)
        |=> ((line_ctrl ^ $past(line_ctrl)) & $past(line_secure)) == '0);

    // R4: unprivileged write never changes control bits of privileged lines
    p_ctrl_priv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_priv && wa == 0)
        |=> ((line_ctrl ^ $past(line_ctrl)) & $past(line_priv)) == '0);

    // R6: nonsecure write leaves the secure configuration unchanged
    p_sec_ns_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure && wa == 1) |=> $stable(line_secure));

    // R7: unprivileged write leaves the privileged configuration unchanged
    p_priv_up_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_priv && wa == 2) |=> $stable(line_priv));

    // R8: nonsecure read of the lock register returns zero
    p_lock_ns_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_secure && wa == 3) |-> rsp_rdata == 32'h0);

    // R9: lock is sticky and freezes both protection registers
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prot_locked |=> prot_locked);
    p_prot_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prot_locked |=> ($stable(line_secure) && $stable(line_priv)));

    // R10: a pulse follows only a nonsecure access to a guarded register
    p_ill_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_pulse |-> $past(req_valid && !req_secure && (wa == 1 || wa == 3)));

endmodule

bind line_prot_filter line_prot_checker #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_line_prot_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_secure    (req_secure),
    .req_priv      (req_priv),
    .req_addr      (req_addr),
    .rsp_rdata     (rsp_rdata),
    .illegal_pulse (illegal_pulse),
    .line_ctrl     (line_ctrl),
    .line_secure   (line_secure),
    .line_priv     (line_priv),
    .prot_locked   (prot_locked)
);

// File: tb/line_prot_filter_bench.sv
module line_prot_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 24;
    localparam int NS = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_secure = 1'b0;
    logic          req_priv = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [3:0]    req_be = '0;
    logic [31:0]   rsp_rdata;
    logic          illegal_pulse;
    logic [NL-1:0] line_ctrl;
    logic [NS*8-1:0] port_sel;
    logic [NL-1:0] line_secure;
    logic [NL-1:0] line_priv;
    logic          prot_locked;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_prot_filter #(.NUM_LINES(NL), .NUM_SEL(NS), .ADDR_W(AW)) u_line_prot_filter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_priv(req_priv), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rsp_rdata(rsp_rdata),
        .illegal_pulse(illegal_pulse), .line_ctrl(line_ctrl), .port_sel(port_sel),
        .line_secure(line_secure), .line_priv(line_priv), .prot_locked(prot_locked)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // One access: drive at negedge, sample read data before the edge,
    // then sample the pulse in the following cycle and the cycle after.
    task automatic access(input logic wr, input logic [AW-1:0] addr,
                          input logic [31:0] data, input logic [3:0] be,
                          input logic sec, input logic prv,
                          output logic [31:0] rd, output logic ill1, output logic ill2);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_wdata = data; req_be = be; req_secure = sec; req_priv = prv;
        #1 rd = rsp_rdata;
        @(negedge clk);
        ill1 = illegal_pulse;
        req_valid = 1'b0; req_write = 1'b0;
        @(negedge clk);
        ill2 = illegal_pulse;
    endtask

    task automatic wr_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [3:0] be, input logic s, input logic p, input logic exp_ill);
        logic [31:0] rd; logic i1, i2;
        access(1'b1, a, d, be, s, p, rd, i1, i2);
        check({tag, " pulse"}, {31'b0, i1}, {31'b0, exp_ill});
        check({tag, " pulse fall R10"}, {31'b0, i2}, 32'h0);
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic s,
                          input logic p, input logic [31:0] exp, input logic exp_ill);
        logic [31:0] rd; logic i1, i2;
        access(1'b0, a, 32'h0, 4'h0, s, p, rd, i1, i2);
        check({tag, " data"}, rd, exp);
        check({tag, " pulse"}, {31'b0, i1}, {31'b0, exp_ill});
        check({tag, " pulse fall R10"}, {31'b0, i2}, 32'h0);
    endtask

    task automatic t_reset;
        check("R1 ctrl", {8'h0, line_ctrl}, 32'h0);
        check("R1 sel lo", port_sel[31:0], 32'h0);
        check("R1 sel hi", port_sel[127:96], 32'h0);
        check("R1 sec", {8'h0, line_secure}, 32'h0);
        check("R1 priv", {8'h0, line_priv}, 32'h0);
        check("R1 lock", {31'b0, prot_locked}, 32'h0);
        check("R1 pulse", {31'b0, illegal_pulse}, 32'h0);
        rd_chk("R1 ctrl read", 8'h00, 1'b1, 1'b1, 32'h0, 1'b0);
    endtask

    task automatic t_ctrl_lanes;
        wr_chk("R2 lanes12", 8'h00, 32'h00FFFF00, 4'b0110, 1'b1, 1'b1, 1'b0);
        check("R2 lanes12", {8'h0, line_ctrl}, 32'h00FFFF00);
        wr_chk("R2 lane0", 8'h00, 32'h000000FF, 4'b0001, 1'b1, 1'b1, 1'b0);
        check("R2 lane0", {8'h0, line_ctrl}, 32'h00FFFFFF);
        wr_chk("R2 clear lane2", 8'h00, 32'h0, 4'b0100, 1'b1, 1'b1, 1'b0);
        check("R2 clear lane2", {8'h0, line_ctrl}, 32'h0000FFFF);
    endtask

    task automatic t_line_protect;
        wr_chk("R7 set sec", 8'h04, 32'h08, 4'hF, 1'b1, 1'b1, 1'b0);
        wr_chk("R7 set priv", 8'h08, 32'h20, 4'hF, 1'b1, 1'b1, 1'b0);
        check("R7 sec value", {8'h0, line_secure}, 32'h08);
        check("R7 priv value", {8'h0, line_priv}, 32'h20);
        wr_chk("R2 fill", 8'h00, 32'hFFFFFF, 4'hF, 1'b1, 1'b1, 1'b0);
        rd_chk("R3 ns read", 8'h00, 1'b0, 1'b1, 32'h00FFFFF7, 1'b0);
        wr_chk("R3 ns write", 8'h00, 32'h0, 4'hF, 1'b0, 1'b1, 1'b0);
        check("R3 ns write", {8'h0, line_ctrl}, 32'h08);
        wr_chk("R4 fill", 8'h00, 32'hFFFFFF, 4'hF, 1'b1, 1'b1, 1'b0);
        wr_chk("R4 up write", 8'h00, 32'h0, 4'hF, 1'b1, 1'b0, 1'b0);
        check("R4 up write", {8'h0, line_ctrl}, 32'h20);
        rd_chk("R4 up read", 8'h00, 1'b1, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_sel_fields;
        wr_chk("R5 w0 full", 8'h20, 32'h04030201, 4'hF, 1'b1, 1'b1, 1'b0);
        check("R5 w0 full", port_sel[31:0], 32'h04030201);
        wr_chk("R5 w0 ns", 8'h20, 32'h0A0A0A0A, 4'hF, 1'b0, 1'b1, 1'b0);
        check("R5 w0 ns", port_sel[31:0], 32'h040A0A0A);
        rd_chk("R5 w0 ns read", 8'h20, 1'b0, 1'b1, 32'h000A0A0A, 1'b0);
        wr_chk("R5 w1 up", 8'h24, 32'h11223344, 4'hF, 1'b1, 1'b0, 1'b0);
        check("R5 w1 up", port_sel[63:32], 32'h11220044);
        wr_chk("R5 w1 lane0", 8'h24, 32'hEEEEEE55, 4'b0001, 1'b1, 1'b1, 1'b0);
        check("R5 w1 lane0", port_sel[63:32], 32'h11220055);
        wr_chk("R5 w3", 8'h2C, 32'hA1B2C3D4, 4'hF, 1'b1, 1'b1, 1'b0);
        check("R5 w3", port_sel[127:96], 32'hA1B2C3D4);
    endtask

    task automatic t_sec_reg;
        wr_chk("R6 ns write", 8'h04, 32'hFFFFFF, 4'hF, 1'b0, 1'b1, 1'b1);
        check("R6 ns write", {8'h0, line_secure}, 32'h08);
        rd_chk("R6 ns read", 8'h04, 1'b0, 1'b0, 32'h08, 1'b0);
    endtask

    task automatic t_cross_guard;
        wr_chk("R7 sec up", 8'h04, 32'h28, 4'hF, 1'b1, 1'b0, 1'b0);
        check("R7 sec up", {8'h0, line_secure}, 32'h08);
        wr_chk("R7 sec up2", 8'h04, 32'h21, 4'hF, 1'b1, 1'b0, 1'b0);
        check("R7 sec up2", {8'h0, line_secure}, 32'h01);
        wr_chk("R7 sec restore", 8'h04, 32'h08, 4'hF, 1'b1, 1'b1, 1'b0);
        wr_chk("R7 priv ns", 8'h08, 32'h28, 4'hF, 1'b0, 1'b1, 1'b0);
        check("R7 priv ns", {8'h0, line_priv}, 32'h20);
        wr_chk("R7 priv ns2", 8'h08, 32'h01, 4'hF, 1'b0, 1'b1, 1'b0);
        check("R7 priv ns2", {8'h0, line_priv}, 32'h01);
        wr_chk("R7 priv up", 8'h08, 32'hFF, 4'hF, 1'b1, 1'b0, 1'b0);
        check("R7 priv up", {8'h0, line_priv}, 32'h01);
        rd_chk("R7 priv read", 8'h08, 1'b0, 1'b0, 32'h01, 1'b0);
        wr_chk("R7 priv restore", 8'h08, 32'h20, 4'hF, 1'b1, 1'b1, 1'b0);
        check("R7 priv restore", {8'h0, line_priv}, 32'h20);
    endtask

    task automatic t_lock;
        rd_chk("R8 ns read", 8'h0C, 1'b0, 1'b1, 32'h0, 1'b1);
        wr_chk("R8 ns write", 8'h0C, 32'h1, 4'hF, 1'b0, 1'b1, 1'b1);
        check("R8 ns write", {31'b0, prot_locked}, 32'h0);
        rd_chk("R8 s read open", 8'h0C, 1'b1, 1'b0, 32'h0, 1'b0);
        wr_chk("R9 set", 8'h0C, 32'h1, 4'h1, 1'b1, 1'b0, 1'b0);
        check("R9 set", {31'b0, prot_locked}, 32'h1);
        wr_chk("R9 clear try", 8'h0C, 32'h0, 4'hF, 1'b1, 1'b1, 1'b0);
        check("R9 clear try", {31'b0, prot_locked}, 32'h1);
        wr_chk("R9 sec frozen", 8'h04, 32'hFFFFFF, 4'hF, 1'b1, 1'b1, 1'b0);
        check("R9 sec frozen", {8'h0, line_secure}, 32'h08);
        wr_chk("R9 priv frozen", 8'h08, 32'hFFFFFF, 4'hF, 1'b1, 1'b1, 1'b0);
        check("R9 priv frozen", {8'h0, line_priv}, 32'h20);
        rd_chk("R9 s read", 8'h0C, 1'b1, 1'b1, 32'h1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_lanes();
        t_line_protect();
        t_sel_fields();
        t_sec_reg();
        t_cross_guard();
        t_lock();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule